// File: doc/BRIEF.md
# Clock-Consumer Stereo Audio Serial Transmitter

This block moves stereo audio words from a small transmit FIFO onto one serial data pin, paced entirely by an external bit clock and left/right word clock. It never generates either clock. An external master owns the serial timing, and the block only follows it. A DMA engine fills the FIFO through a simple write port. A request line tells the engine when there is room. Sticky error flags report FIFO overflow, FIFO underflow and early word-clock edges.

Both serial inputs are brought into the system clock domain through synchronizer chains. Their edges are then detected there. Outgoing data changes only after a falling bit-clock edge, so a receiver can sample on the rising edge. The word clock is active low: a low level marks the left slot. Two framings are selectable. The first is the standard format, where the most significant bit comes one bit clock after the word-clock edge. The second is left-justified, where that bit comes on the edge itself. The sample length is programmable.

Top module: `cmtx_top`

## Requirements
- R1: After reset, sd_out, dreq, en_status and the three status flags are all 0.
- R2: dreq is 1 only when cfg_req_en and cfg_dma_en are both 1 and the FIFO holds at most half of its 16 entries (count of 8 or less).
- R3: A write while the FIFO already holds 16 words is discarded and sets sts_ovf.
- R4: With cfg_i2s=0, the most significant bit of a slot appears after the same falling bit-clock edge on which lrck_in changes. A low lrck_in marks the left slot.
- R5: With cfg_i2s=1, the most significant bit appears one bit-clock period after the lrck_in change.
- R6: cfg_len_m1 holds the sample length minus one (7 to 31). The slot carries wr_data bits [len-1:0], most significant first, followed by zeros to the end of the slot. Bits above the length are ignored.
- R7: Raising cfg_en takes effect only at the start of a left slot, and en_status rises there. Lowering cfg_en takes effect at the next slot start, where en_status falls.
- R8: A slot start that finds the FIFO empty while running sends zeros for that slot and sets sts_udf. Without the stop option, transmission stays enabled.
- R9: With cfg_stop_empty=1, an empty FIFO at a slot start sets sts_udf and halts transmission (en_status 0). Transmission stays halted until cfg_en is lowered and raised again.
- R10: A slot start that arrives while bits of the current sample remain unsent sets sts_fserr.
- R11: Writing 1 to sts_clr bit 0, bit 1 or bit 2 clears sts_ovf, sts_udf or sts_fserr respectively. A new event in the same cycle wins over the clear.
- R12: sd_out changes only in response to a falling bit-clock edge, and holds while the bit clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Transmit enable request |
| cfg_i2s | input | 1 | 1: one-bit data delay, 0: left-justified |
| cfg_len_m1 | input | 5 | Sample length minus one |
| cfg_stop_empty | input | 1 | Halt when the FIFO runs dry |
| cfg_req_en | input | 1 | Data request enable |
| cfg_dma_en | input | 1 | DMA request enable |
| sts_clr | input | 3 | Write-1 clears: bit0 overflow, bit1 underflow, bit2 sync error |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 32 | FIFO write word |
| sclk_in | input | 1 | External bit clock |
| lrck_in | input | 1 | External word clock, low = left |
| sd_out | output | 1 | Serial data |
| dreq | output | 1 | Data request to DMA engine |
| en_status | output | 1 | Enable state confirmed in serial timing |
| sts_ovf | output | 1 | Sticky FIFO overflow |
| sts_udf | output | 1 | Sticky FIFO underflow |
| sts_fserr | output | 1 | Sticky early word-clock error |

## Verification
The bench acts as the external master and records sd_out at each rising bit-clock edge, then decodes the stream into slots.

It targets these faults:
- An off-by-one in the one-bit delay would shift every decoded word by a bit.
- A 16-bit sample in a 32-bit slot would show its upper word bits if they were not masked.
- A seventeenth write that overwrote a stored entry would show up as a non-zero slot where zeros belong after the FIFO drains.
- A halt that cleared itself would leak freshly written words onto the line.
- A mis-timed enable would miss the first left sample or begin mid-frame.
- A 32-bit length clocked in 16-bit slots must raise the sync error.

// File: rtl/cmtx_pkg.sv
package cmtx_pkg;
  localparam int CLR_OVF   = 0;
  localparam int CLR_UDF   = 1;
  localparam int CLR_FSERR = 2;

  typedef struct packed {
    logic ovf;
    logic udf;
    logic fserr;
  } cmtx_evt_t;
endpackage

// File: rtl/cmtx_pinsync.sv
module cmtx_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic lrck_in,
  output logic fall,
  output logic ws_s
);
  logic [STAGES:0]   b_q;
  logic [STAGES-1:0] w_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_q <= '1;
      w_q <= '1;
    end else begin
      b_q <= {b_q[STAGES-1:0], sclk_in};
      w_q <= {w_q[STAGES-2:0], lrck_in};
    end
  end

  assign fall = b_q[STAGES] & ~b_q[STAGES-1];
  assign ws_s = w_q[STAGES-1];
endmodule

// File: rtl/cmtx_fifo.sv
module cmtx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       ovf_evt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              full, wr_ok, rd_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign wr_ok   = wr_en && !full;
  assign rd_ok   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      ovf_evt <= 1'b0;
    end else begin
      ovf_evt <= wr_en && full;
      if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (rd_ok) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R3: a write into a full FIFO leaves the fill level at the top
  p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (count == CW'(DEPTH)));

  // R3: fill level never exceeds the depth
  always_comb begin
    if (!rst) p_count_bound_r3: assert (count <= CW'(DEPTH));
  end
endmodule

// File: rtl/cmtx_shift.sv
module cmtx_shift #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              ws_s,
  input  logic              cfg_en,
  input  logic              cfg_i2s,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic              cfg_stop,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              pop,
  output logic              sd_out,
  output logic              active,
  output logic              udf_evt,
  output logic              fserr_evt
);
  localparam logic [LEN_W-1:0] MSB_IDX = LEN_W'(DATA_W-1);

  logic              ws_prev, edge_d, halted;
  logic              ws_edge, start, go;
  logic [DATA_W-1:0] sh;
  logic [LEN_W-1:0]  remain;

  always_comb begin
    ws_edge = fall && (ws_s != ws_prev);
    start   = fall && (cfg_i2s ? edge_d : ws_edge);
    go      = active ? cfg_en : (cfg_en && !halted && !ws_s);
    pop     = start && go && !fifo_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_prev   <= 1'b1;
      edge_d    <= 1'b0;
      halted    <= 1'b0;
      active    <= 1'b0;
      sd_out    <= 1'b0;
      sh        <= '0;
      remain    <= '0;
      udf_evt   <= 1'b0;
      fserr_evt <= 1'b0;
    end else begin
      udf_evt   <= 1'b0;
      fserr_evt <= 1'b0;
      if (!cfg_en) halted <= 1'b0;
      if (fall) begin
        ws_prev <= ws_s;
        edge_d  <= ws_edge;
      end
      if (start) begin
        fserr_evt <= active && (remain != '0);
        if (go && !fifo_empty) begin
          active <= 1'b1;
          sd_out <= fifo_data[cfg_len_m1];
          sh     <= (fifo_data << (MSB_IDX - cfg_len_m1)) << 1;
          remain <= cfg_len_m1;
        end else if (go && !cfg_stop) begin
          active  <= 1'b1;
          udf_evt <= 1'b1;
          sd_out  <= 1'b0;
          sh      <= '0;
          remain  <= cfg_len_m1;
        end else begin
          active <= 1'b0;
          sd_out <= 1'b0;
          sh     <= '0;
          remain <= '0;
          if (go) begin
            udf_evt <= 1'b1;
            halted  <= 1'b1;
          end
        end
      end else if (fall) begin
        if (active && remain != '0) begin
          sd_out <= sh[DATA_W-1];
          sh     <= {sh[DATA_W-2:0], 1'b0};
          remain <= remain - LEN_W'(1);
        end else begin
          sd_out <= 1'b0;
        end
      end
    end
  end

  // R12: data only moves after a falling bit-clock edge
  p_sd_on_fall_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_out) |-> $past(fall));

  // R7: transmission only starts in a left slot with enable requested
  p_enable_on_left_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(!ws_s && cfg_en));

  // R8: an underflow slot begins with a zero bit
  p_udf_zero_r8: assert property (@(posedge clk) disable iff (rst)
    udf_evt |-> (sd_out == 1'b0));
endmodule

// File: rtl/cmtx_top.sv
module cmtx_top
  import cmtx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_en,
  input  logic        cfg_i2s,
  input  logic [4:0]  cfg_len_m1,
  input  logic        cfg_stop_empty,
  input  logic        cfg_req_en,
  input  logic        cfg_dma_en,
  input  logic [2:0]  sts_clr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        sclk_in,
  input  logic        lrck_in,
  output logic        sd_out,
  output logic        dreq,
  output logic        en_status,
  output logic        sts_ovf,
  output logic        sts_udf,
  output logic        sts_fserr
);
  localparam int CW    = $clog2(FIFO_DEPTH+1);
  localparam int LEN_W = $clog2(DATA_W);
  localparam int HALF  = FIFO_DEPTH / 2;

  logic              fall, ws_s, pop, fifo_empty;
  logic [DATA_W-1:0] fifo_data;
  logic [CW-1:0]     fifo_count;
  cmtx_evt_t         evt;

  cmtx_pinsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .lrck_in(lrck_in),
    .fall(fall), .ws_s(ws_s)
  );

  cmtx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data[DATA_W-1:0]),
    .rd_en(pop), .rd_data(fifo_data), .empty(fifo_empty),
    .count(fifo_count), .ovf_evt(evt.ovf)
  );

  cmtx_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .fall(fall), .ws_s(ws_s),
    .cfg_en(cfg_en), .cfg_i2s(cfg_i2s), .cfg_len_m1(cfg_len_m1[LEN_W-1:0]),
    .cfg_stop(cfg_stop_empty), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .pop(pop), .sd_out(sd_out), .active(en_status),
    .udf_evt(evt.udf), .fserr_evt(evt.fserr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dreq      <= 1'b0;
      sts_ovf   <= 1'b0;
      sts_udf   <= 1'b0;
      sts_fserr <= 1'b0;
    end else begin
      dreq      <= cfg_req_en && cfg_dma_en && (fifo_count <= CW'(HALF));
      sts_ovf   <= (sts_ovf   && !sts_clr[CLR_OVF])   || evt.ovf;
      sts_udf   <= (sts_udf   && !sts_clr[CLR_UDF])   || evt.udf;
      sts_fserr <= (sts_fserr && !sts_clr[CLR_FSERR]) || evt.fserr;
    end
  end

  // R2: request only when both enables were set
  p_dreq_gate_r2: assert property (@(posedge clk) disable iff (rst)
    dreq |-> $past(cfg_req_en && cfg_dma_en));

  // R11: a flag stays set unless cleared
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (sts_ovf && !sts_clr[CLR_OVF]) |=> sts_ovf);
endmodule

// File: tb/cmtx_top_tb.sv
module cmtx_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 0, cfg_i2s = 0, cfg_stop_empty = 0, cfg_req_en = 0, cfg_dma_en = 0;
  logic [4:0]  cfg_len_m1 = 5'd15;
  logic [2:0]  sts_clr = '0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic        sclk_in = 1'b1, lrck_in = 1'b1;
  logic        sd_out, dreq, en_status, sts_ovf, sts_udf, sts_fserr;

  int errors = 0, checks = 0, ncap = 0, hi_miss = 0;
  logic cap [0:1023];

  always #2.5 clk = ~clk;

  cmtx_top u_dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_i2s(cfg_i2s), .cfg_len_m1(cfg_len_m1),
    .cfg_stop_empty(cfg_stop_empty), .cfg_req_en(cfg_req_en), .cfg_dma_en(cfg_dma_en),
    .sts_clr(sts_clr), .wr_en(wr_en), .wr_data(wr_data), .sclk_in(sclk_in),
    .lrck_in(lrck_in), .sd_out(sd_out), .dreq(dreq), .en_status(en_status),
    .sts_ovf(sts_ovf), .sts_udf(sts_udf), .sts_fserr(sts_fserr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cfg_en = 0; cfg_i2s = 0; cfg_stop_empty = 0; cfg_req_en = 0; cfg_dma_en = 0;
    cfg_len_m1 = 5'd15; sts_clr = '0; wr_en = 0; sclk_in = 1; lrck_in = 1; ncap = 0;
    tick(3);
    rst = 0;
    tick(1);
  endtask

  task automatic push(input logic [31:0] w);
    wr_en = 1; wr_data = w;
    tick(1);
    wr_en = 0;
  endtask

  task automatic bit_cycle(input logic ws);
    logic v;
    sclk_in = 0; lrck_in = ws;
    tick(4);
    v = sd_out;
    cap[ncap] = v; ncap++;
    sclk_in = 1;
    tick(4);
    if (sd_out !== v) hi_miss++;
  endtask

  task automatic run_slots(input int n, input int slot);
    for (int s = 0; s < n; s++)
      for (int i = 0; i < slot; i++)
        bit_cycle(s % 2 == 1);
  endtask

  function automatic logic [31:0] get_word(input int idx, input int len);
    logic [31:0] w = '0;
    for (int k = 0; k < len; k++) w = {w[30:0], cap[idx+k]};
    return w;
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R1 sd_out", sd_out, 0);
    chk("R1 dreq", dreq, 0);
    chk("R1 en_status", en_status, 0);
    chk("R1 flags", {sts_ovf, sts_udf, sts_fserr}, 0);
  endtask

  task automatic t_dreq();
    do_reset();
    cfg_req_en = 1; tick(3);
    chk("R2 dma off", dreq, 0);
    cfg_dma_en = 1; tick(3);
    chk("R2 both on", dreq, 1);
    for (int i = 0; i < 9; i++) push(i);
    tick(3);
    chk("R2 above half", dreq, 0);
  endtask

  task automatic t_ovf_lj();
    do_reset();
    for (int i = 0; i < 17; i++) push(32'h1000 + i);
    tick(2);
    chk("R3 ovf flag", sts_ovf, 1);
    sts_clr = 3'b001; tick(1); sts_clr = 0; tick(2);
    chk("R11 ovf clear", sts_ovf, 0);
    cfg_en = 1; tick(4);
    chk("R7 no enable before left slot", en_status, 0);
    hi_miss = 0;
    run_slots(18, 16);
    for (int s = 0; s < 16; s++)
      chk("R4 lj word", get_word(s*16, 16), 32'h1000 + s);
    chk("R3 dropped word absent", get_word(16*16, 16), 0);
    chk("R8 udf flag", sts_udf, 1);
    chk("R8 stays enabled", en_status, 1);
    chk("R12 stable while high", hi_miss, 0);
  endtask

  task automatic t_i2s32();
    logic [31:0] w [4] = '{32'hF0E1D2C3, 32'h80000001, 32'h12345678, 32'hA5A55A5A};
    do_reset();
    cfg_i2s = 1; cfg_len_m1 = 5'd31;
    for (int i = 0; i < 4; i++) push(w[i]);
    cfg_en = 1;
    run_slots(4, 32);
    bit_cycle(0);
    for (int s = 0; s < 4; s++)
      chk("R5 i2s word", get_word(s*32 + 1, 32), w[s]);
    chk("R5 first bit idle", cap[0], 0);
    chk("R10 no sync error", sts_fserr, 0);
    cfg_en = 0; tick(3);
    chk("R7 disable waits for slot", en_status, 1);
    bit_cycle(0);
    chk("R7 disabled at slot", en_status, 0);
  endtask

  task automatic t_pad();
    do_reset();
    cfg_len_m1 = 5'd15;
    push(32'hABCD1234); push(32'h5555FFFF);
    cfg_en = 1;
    run_slots(2, 32);
    chk("R6 low half sent", get_word(0, 16), 32'h1234);
    chk("R6 zero fill", get_word(16, 16), 0);
    chk("R6 second word", get_word(32, 16), 32'hFFFF);
    chk("R6 second fill", get_word(48, 16), 0);
  endtask

  task automatic t_stop();
    do_reset();
    cfg_stop_empty = 1;
    push(32'h0000C001); push(32'h0000C002);
    cfg_en = 1;
    run_slots(4, 16);
    chk("R9 data before halt", get_word(16, 16), 32'hC002);
    chk("R9 halted", en_status, 0);
    chk("R9 udf flag", sts_udf, 1);
    push(32'h0000D001); push(32'h0000D002);
    run_slots(2, 16);
    chk("R9 stays halted", get_word(64, 32), 0);
    chk("R9 still off", en_status, 0);
    cfg_en = 0; tick(2); cfg_en = 1; tick(2);
    run_slots(2, 16);
    chk("R9 resumes left", get_word(96, 16), 32'hD001);
    chk("R9 resumes right", get_word(112, 16), 32'hD002);
    sts_clr = 3'b010; tick(1); sts_clr = 0; tick(2);
    chk("R11 udf clear", sts_udf, 0);
  endtask

  task automatic t_fserr();
    do_reset();
    cfg_len_m1 = 5'd31;
    for (int i = 0; i < 4; i++) push(32'hFFFF0000 + i);
    cfg_en = 1;
    run_slots(3, 16);
    chk("R10 sync error", sts_fserr, 1);
    chk("R10 others clear", {sts_ovf, sts_udf}, 0);
    sts_clr = 3'b100; tick(1); sts_clr = 0; tick(2);
    chk("R11 fserr clear", sts_fserr, 0);
  endtask

  initial begin
    t_reset();
    t_dreq();
    t_ovf_lj();
    t_i2s32();
    t_pad();
    t_stop();
    t_fserr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule